// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block times the clock line of an I2C master. A reference clock is first divided by a power of two chosen by a 3-bit select. Two 5-bit fields then set how many of those divided cycles SCL is held low and how many it is left released. Each phase also carries a fixed overhead. The overhead covers the time taken to synchronize and de-glitch the returning SCL level: four divided cycles when the divider is bypassed, and three otherwise.

Once the overhead part of the released phase has elapsed, counting stops until the filtered bus level is seen high. A slave that holds SCL low therefore lengthens the period by exactly the time it stretches. The block also gives the byte controller two one-cycle strobes. One marks the middle of the low phase, where SDA may change. The other marks the middle of the high phase, where SDA is sampled and START or STOP is detected.

Configuration is captured only while the soft-hold input is asserted. When hold is released, the generator starts with a released (high) phase and runs freely.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: The reference clock is divided by 2^S, where S is `cfg_div_sel`; S = 0 means no division. Every phase length and strobe position below scales by 2^S reference cycles.
- R2: Without stretching, the low phase (`scl_drive_low` = 1, meaning SCL is pulled low) lasts (L + V) × 2^S reference cycles. L is the low field and V is 4 when S = 0, otherwise 3.
- R3: Without stretching, the released phase (`scl_drive_low` = 0) lasts (H + V) × 2^S reference cycles, where H is the high field.
- R4: A period field programmed to 0 behaves exactly as the value 1.
- R5: With S = 0, if SCL is held low externally until just after the R-th clock edge of the released phase (R ≥ 1), that phase lasts H + V + R cycles.
- R6: A high pulse on `scl_in` lasting one reference cycle is rejected by the input filter and does not end a stretch.
- R7: `sda_update_stb` pulses once per low phase, for one cycle, first seen ((L + V − 1) div 2 + 1) × 2^S cycles after the low phase starts.
- R8: `sda_sample_stb` pulses once per released phase, for one cycle, first seen (V + (H − 1) div 2 + 1) × 2^S cycles after the phase starts, plus R when stretched. The two strobes are never high together.
- R9: While `soft_hold` is high, SCL is released and both strobes stay low. After hold drops, the first phase is a released phase of (H + V) × 2^S cycles.
- R10: Changes to `cfg_div_sel`, `cfg_high` or `cfg_low` while `soft_hold` is low have no effect.
- R11: While `rst_n` is low, `scl_drive_low`, `sda_update_stb` and `sda_sample_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_hold | input | 1 | Holds the generator idle and captures configuration |
| cfg_div_sel | input | 3 | Divider select, divide by 2^value |
| cfg_high | input | 5 | Released-phase count, 1..31 |
| cfg_low | input | 5 | Low-phase count, 1..31 |
| scl_in | input | 1 | Sensed SCL bus level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_update_stb | output | 1 | Middle-of-low strobe |
| sda_sample_stb | output | 1 | Middle-of-high strobe |

## Verification
The hardest situation to reach is a one-cycle SCL glitch that lands exactly while the counter is stalled at the end of the overhead window. A glitch at any other time is masked anyway. The bench builds `scl_in` from the block's own drive plus an external hold-low and a glitch pulse. It counts clock edges from the start of the released phase and places the glitch right at the stall point, four edges in, and releases the stretch later. The stretched period then shows whether the glitch leaked through the filter.

// File: rtl/i2c_srg_pkg.sv
package i2c_srg_pkg;
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } srg_phase_e;

  function automatic int unsigned srg_len_width(int unsigned cnt_w, int unsigned ovh);
    return $clog2((1 << cnt_w) + ovh);
  endfunction
endpackage

// File: rtl/srg_prescaler.sv
module srg_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, limit;

  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_W; i++) begin
      limit[i] = (i < int'(sel));
    end
  end

  assign tick = (div_q == limit);

  always_comb begin
    if (clr || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R1: divider count stays inside the selected ratio
  assert_div_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= limit);
endmodule

// File: rtl/srg_scl_filter.sv
module srg_scl_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic scl_seen
);
  logic s1_q, s2_q, s3_q, filt_q, filt_d;

  always_comb begin
    filt_d = filt_q;
    if (s2_q == s3_q) filt_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      filt_q <= 1'b1;
    end else begin
      s1_q   <= scl_raw;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      filt_q <= filt_d;
    end
  end

  assign scl_seen = filt_q;

  // R6: a level change is accepted only after two equal synchronized samples
  assert_glitch_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(s2_q) == filt_q && $past(s3_q) == filt_q));
endmodule

// File: rtl/srg_phase_seq.sv
module srg_phase_seq
  import i2c_srg_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int OVH_BYP  = 4,
  parameter int OVH_DIV  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             bypass,
  input  logic [CNT_W-1:0] hi_val,
  input  logic [CNT_W-1:0] lo_val,
  input  logic             scl_seen,
  output logic             drive_low,
  output logic             stb_lo,
  output logic             stb_hi
);
  localparam int OVH_MAX = (OVH_BYP > OVH_DIV) ? OVH_BYP : OVH_DIV;
  localparam int PH_W    = srg_len_width(CNT_W, OVH_MAX);

  srg_phase_e      phase_q, phase_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            stb_lo_q, stb_lo_d, stb_hi_q, stb_hi_d;
  logic [PH_W-1:0] ovh, hi_eff, lo_eff, len_hi, len_lo, len_cur, mid_lo, mid_hi;
  logic            adv, last;

  always_comb begin
    ovh     = bypass ? PH_W'(OVH_BYP) : PH_W'(OVH_DIV);
    hi_eff  = (hi_val == '0) ? PH_W'(1) : PH_W'(hi_val);
    lo_eff  = (lo_val == '0) ? PH_W'(1) : PH_W'(lo_val);
    len_hi  = hi_eff + ovh;
    len_lo  = lo_eff + ovh;
    mid_lo  = (len_lo - PH_W'(1)) >> 1;
    mid_hi  = ovh + ((hi_eff - PH_W'(1)) >> 1);
    len_cur = (phase_q == PH_LOW) ? len_lo : len_hi;
    adv     = tick && ((phase_q == PH_LOW) || (cnt_q < ovh) || scl_seen);
    last    = (cnt_q == len_cur - PH_W'(1));
  end

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    stb_lo_d = 1'b0;
    stb_hi_d = 1'b0;
    if (clr) begin
      phase_d = PH_HIGH;
      cnt_d   = '0;
    end else if (adv) begin
      stb_lo_d = (phase_q == PH_LOW)  && (cnt_q == mid_lo);
      stb_hi_d = (phase_q == PH_HIGH) && (cnt_q == mid_hi);
      if (last) begin
        cnt_d   = '0;
        phase_d = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      end else begin
        cnt_d = cnt_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HIGH;
      cnt_q    <= '0;
      stb_lo_q <= 1'b0;
      stb_hi_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      stb_lo_q <= stb_lo_d;
      stb_hi_q <= stb_hi_d;
    end
  end

  assign drive_low = (phase_q == PH_LOW);
  assign stb_lo    = stb_lo_q;
  assign stb_hi    = stb_hi_q;

  // R2: the phase counter never passes the programmed length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_cur);

  // R2: the low phase is never held back by the bus level
  assert_low_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && phase_q == PH_LOW) |=> (cnt_q != $past(cnt_q)));

  // R5: past the overhead window, the high count waits for SCL seen high
  assert_stretch_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && tick && phase_q == PH_HIGH && cnt_q >= ovh && !scl_seen)
      |=> (cnt_q == $past(cnt_q) && phase_q == PH_HIGH));

  // R8: the two strobes are exclusive
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb_lo_q && stb_hi_q));
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen #(
  parameter int SEL_W   = 3,
  parameter int CNT_W   = 5,
  parameter int OVH_BYP = 4,
  parameter int OVH_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_hold,
  input  logic [SEL_W-1:0] cfg_div_sel,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             sda_update_stb,
  output logic             sda_sample_stb
);
  logic             rst_meta_q, rst_sync_q;
  logic [SEL_W-1:0] sh_sel_q, sh_sel_d;
  logic [CNT_W-1:0] sh_hi_q, sh_hi_d, sh_lo_q, sh_lo_d;
  logic             tick, scl_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    sh_sel_d = sh_sel_q;
    sh_hi_d  = sh_hi_q;
    sh_lo_d  = sh_lo_q;
    if (soft_hold) begin
      sh_sel_d = cfg_div_sel;
      sh_hi_d  = cfg_high;
      sh_lo_d  = cfg_low;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      sh_sel_q <= '0;
      sh_hi_q  <= '1;
      sh_lo_q  <= '1;
    end else begin
      sh_sel_q <= sh_sel_d;
      sh_hi_q  <= sh_hi_d;
      sh_lo_q  <= sh_lo_d;
    end
  end

  srg_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (soft_hold),
    .sel   (sh_sel_q),
    .tick  (tick)
  );

  srg_scl_filter u_filt (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .scl_raw  (scl_in),
    .scl_seen (scl_seen)
  );

  srg_phase_seq #(
    .CNT_W   (CNT_W),
    .OVH_BYP (OVH_BYP),
    .OVH_DIV (OVH_DIV)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .clr       (soft_hold),
    .tick      (tick),
    .bypass    (sh_sel_q == '0),
    .hi_val    (sh_hi_q),
    .lo_val    (sh_lo_q),
    .scl_seen  (scl_seen),
    .drive_low (scl_drive_low),
    .stb_lo    (sda_update_stb),
    .stb_hi    (sda_sample_stb)
  );

  // R9: hold releases SCL and silences both strobes
  assert_hold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    soft_hold |=> (!scl_drive_low && !sda_update_stb && !sda_sample_stb));

  // R10: captured configuration is frozen while running
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !soft_hold |=> ($stable(sh_sel_q) && $stable(sh_hi_q) && $stable(sh_lo_q)));
endmodule

// File: tb/i2c_scl_rate_gen_tb_top.sv
module i2c_scl_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int NVEC       = 6;
  // {sel[12:10], low[9:5], high[4:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 5'd1,  5'd1},
    {3'd0, 5'd31, 5'd31},
    {3'd0, 5'd0,  5'd0},
    {3'd1, 5'd5,  5'd3},
    {3'd3, 5'd10, 5'd20},
    {3'd7, 5'd2,  5'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n, soft_hold, ext_low, glitch;
  logic [2:0] cfg_div_sel;
  logic [4:0] cfg_high, cfg_low;
  logic       scl_in, scl_drive_low, sda_update_stb, sda_sample_stb;
  int         n_checks = 0;
  int         n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_in = !scl_drive_low && (!ext_low || glitch);

  i2c_scl_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .soft_hold(soft_hold),
    .cfg_div_sel(cfg_div_sel), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sda_update_stb(sda_update_stb), .sda_sample_stb(sda_sample_stb)
  );

  function automatic int ovh(int s);  return (s == 0) ? 4 : 3; endfunction
  function automatic int eff(int v);  return (v == 0) ? 1 : v; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic apply_cfg(input int s, input int l, input int h);
    @(posedge clk); #1;
    soft_hold = 1'b1;
    cfg_div_sel = 3'(s); cfg_low = 5'(l); cfg_high = 5'(h);
    repeat (2) @(posedge clk);
    #1 soft_hold = 1'b0;
  endtask

  task automatic measure_cycle(input int stretch_r, input bit do_glitch,
                               output int lo_len, output int lo_at, output int lo_n,
                               output int hi_len, output int hi_at, output int hi_n);
    int n;
    lo_at = 0; lo_n = 0; hi_at = 0; hi_n = 0;
    @(posedge scl_drive_low);
    ext_low = (stretch_r > 0);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
      if (sda_update_stb) begin lo_n++; if (lo_at == 0) lo_at = n; end
    end while (scl_drive_low);
    lo_len = n;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
      if (n == stretch_r) ext_low = 1'b0;
      if (n == 4) glitch = do_glitch;
      if (n == 5) glitch = 1'b0;
      if (sda_sample_stb) begin hi_n++; if (hi_at == 0) hi_at = n; end
    end while (!scl_drive_low);
    hi_len = n;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    finish_run();
  end

  initial begin
    int ll, la, ln, hl, ha, hn, s, l, h, p, v, n;
    rst_n = 1'b0; soft_hold = 1'b1; ext_low = 1'b0; glitch = 1'b0;
    cfg_div_sel = '0; cfg_high = 5'd1; cfg_low = 5'd1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset drive", int'(scl_drive_low), 0);
    chk("R11 reset update strobe", int'(sda_update_stb), 0);
    chk("R11 reset sample strobe", int'(sda_sample_stb), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // table walk: R1 R2 R3 R4 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      s = int'(VEC[i][12:10]); l = int'(VEC[i][9:5]); h = int'(VEC[i][4:0]);
      p = 1 << s; v = ovh(s);
      apply_cfg(s, l, h);
      measure_cycle(0, 1'b0, ll, la, ln, hl, ha, hn);
      chk("R2 R4 low length", ll, (eff(l) + v) * p);
      chk("R3 R4 high length", hl, (eff(h) + v) * p);
      chk("R7 update strobe position", la, ((eff(l) + v - 1) / 2 + 1) * p);
      chk("R7 update strobe count", ln, 1);
      chk("R8 sample strobe position", ha, (v + (eff(h) - 1) / 2 + 1) * p);
      chk("R8 sample strobe count", hn, 1);
    end

    // R5: stretched high phase
    apply_cfg(0, 6, 3);
    measure_cycle(5, 1'b0, ll, la, ln, hl, ha, hn);
    chk("R5 stretched high length", hl, 3 + 4 + 5);
    chk("R8 stretched sample strobe", ha, 4 + 1 + 1 + 5);

    // R6: one-cycle glitch at the stall point must not end the stretch
    measure_cycle(9, 1'b1, ll, la, ln, hl, ha, hn);
    chk("R6 glitch ignored high length", hl, 3 + 4 + 9);
    chk("R6 glitch sample strobe", ha, 4 + 1 + 1 + 9);

    // R9: hold behaviour and restart
    apply_cfg(2, 4, 5);
    repeat (7) @(posedge clk);
    #1 soft_hold = 1'b1;
    n = 0;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      if (scl_drive_low || sda_update_stb || sda_sample_stb) n++;
    end
    chk("R9 quiet while held", n, 0);
    soft_hold = 1'b0;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!scl_drive_low);
    chk("R9 first released phase", n, (5 + 3) * 4);

    // R10: inputs changed while running are ignored
    cfg_div_sel = 3'd0; cfg_low = 5'd9; cfg_high = 5'd9;
    measure_cycle(0, 1'b0, ll, la, ln, hl, ha, hn);
    chk("R10 low length unchanged", ll, (4 + 3) * 4);
    chk("R10 high length unchanged", hl, (5 + 3) * 4);
    chk("R10 strobe position unchanged", la, ((4 + 3 - 1) / 2 + 1) * 4);

    finish_run();
  end
endmodule